// File: doc/BRIEF.md
# Serial Switch-Status Port with Change Interrupt

This block is the host-facing serial slave of a multi-input switch monitor. It watches 22 already-debounced switch inputs. On each 24-bit serial frame it returns a snapshot of those inputs and a latched interrupt flag. In the same frame it takes in a 24-bit command word, which it presents as a parallel register. The low 22 bits of that register act as a per-input interrupt enable mask.

All serial pins are oversampled by the system clock through two-flop synchronizers, and edges are detected in that clock domain. The chip-select edges carry the handshake:
- The falling edge freezes the switch states and the interrupt flag into the output shifter.
- The rising edge commits the command and releases the active-low interrupt.
- If an enabled input changed while the frame was open, the interrupt stays asserted into the next frame.

Top module: `spi_switch_monitor`

## Requirements
- R1: A frame of exactly 24 falling SCLK edges while CS is low captures SI on each falling edge, MSB first. On the CS rising edge the captured word appears on cmd_o.
- R2: Once CS falls, SO carries the status MSB (index 23). Each rising SCLK edge after the first falling edge presents the next lower bit, so the host reads the word MSB first on the falling edges.
- R3: Status word layout: index 23 is the interrupt flag latched at the CS falling edge, index 22 reads 0, and index k (k = 0..21) is switch input k, with a high input (closed switch) reading 1.
- R4: The status word is the snapshot taken at the CS falling edge. Switch changes during the frame do not alter the bits shifted out.
- R5: While CS is high, SCLK and SI are ignored: cmd_o does not change and so_oe_o stays low.
- R6: A frame that ends after other than 24 falling SCLK edges is discarded, and cmd_o keeps its previous value.
- R7: A change in either direction of switch input k while cmd_o bit k is 1 drives irq_no low.
- R8: A change of switch input k while cmd_o bit k is 0 leaves irq_no unaffected.
- R9: The CS rising edge releases irq_no high. If an enabled input changed while CS was low, irq_no instead stays low.
- R10: so_oe_o is high while CS is low and low while CS is high, within a few system clocks of synchronizer latency. After reset, cmd_o is 0, irq_no is high and so_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data into the block |
| so_o | output | 1 | Serial data out of the block |
| so_oe_o | output | 1 | Drive enable for so_o; the pad is high impedance when low |
| sw_i | input | 22 | Debounced switch inputs, high means closed |
| irq_no | output | 1 | Interrupt, active low |
| cmd_o | output | 24 | Last completed command word; bits 21..0 are the interrupt enables |

## Verification
The hardest case to reach is an enabled switch change that lands while CS is low. That change must leave the already-latched status word untouched and keep the interrupt asserted past the CS rising edge. The frame driver takes a bit index and a new switch vector, and it swaps the switch inputs right after the host samples that bit. The scoreboard then expects the pre-change snapshot for that frame, a low interrupt afterwards, and the new switch state with the flag set in the following frame.

// File: rtl/swmon_pkg.sv
package swmon_pkg;
  localparam int FRAME_W = 24;
  localparam int N_SW    = 22;
endpackage

// File: rtl/swmon_sync.sv
module swmon_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/swmon_shift.sv
module swmon_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic               cs_fall_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               si_i,
  input  logic [FRAME_W-1:0] status_i,
  output logic               so_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic               full_o
);
  localparam int                CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (cs_fall_i) begin
      tx_q  <= status_i;
      cnt_q <= '0;
    end else if (frame_i) begin
      if (sclk_fall_i) begin
        rx_q <= {rx_q[FRAME_W-2:0], si_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      // first rising edge precedes any sample; hold MSB for it
      if (sclk_rise_i && cnt_q != '0) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign so_o   = tx_q[FRAME_W-1];
  assign rx_o   = rx_q;
  assign full_o = (cnt_q == CNT_FULL);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R6
  AST_IDLE_HOLDS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(rx_q)); // R5
  AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> so_o == $past(status_i[FRAME_W-1])); // R4
endmodule

// File: rtl/swmon_irq.sv
module swmon_irq #(
  parameter int N_SW = 22
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_SW-1:0] sw_i,
  input  logic [N_SW-1:0] mask_i,
  input  logic            frame_i,
  input  logic            cs_rise_i,
  output logic            irq_o
);
  logic [N_SW-1:0] sw_prev_q;
  logic            irq_q, dirty_q, chg;

  assign chg = |((sw_i ^ sw_prev_q) & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_prev_q <= '0;
      irq_q     <= 1'b0;
      dirty_q   <= 1'b0;
    end else begin
      sw_prev_q <= sw_i;
      if (cs_rise_i) begin
        irq_q   <= dirty_q | chg;
        dirty_q <= 1'b0;
      end else begin
        if (chg) irq_q <= 1'b1;
        if (chg && frame_i) dirty_q <= 1'b1;
      end
    end
  end

  assign irq_o = irq_q;

  AST_CHANGE_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> irq_q); // R7
  AST_RISE_CLEARS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && !dirty_q && !chg |=> !irq_q); // R9
  AST_DIRTY_HOLDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i && dirty_q |=> irq_q); // R9
endmodule

// File: rtl/spi_switch_monitor.sv
module spi_switch_monitor
  import swmon_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int NS = N_SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          si_i,
  output logic          so_o,
  output logic          so_oe_o,
  input  logic [NS-1:0] sw_i,
  output logic          irq_no,
  output logic [FW-1:0] cmd_o
);
  logic [2:0]    pins_s;
  logic [NS-1:0] sw_s;
  logic          cs_s, sclk_s, si_s, cs_d, sclk_d;
  logic          cs_fall, cs_rise, sclk_rise, sclk_fall, frame;
  logic          irq, full;
  logic [FW-1:0] status, rx, cmd_q;

  swmon_sync #(.W(3), .RST_VAL(3'b100)) u_pin_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sclk_i, si_i}), .q_o(pins_s));
  swmon_sync #(.W(NS), .RST_VAL('0)) u_sw_sync (
    .clk_i, .rst_ni, .d_i(sw_i), .q_o(sw_s));

  assign {cs_s, sclk_s, si_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign frame     = !cs_s;
  assign cs_fall   = cs_d && !cs_s;
  assign cs_rise   = !cs_d && cs_s;
  assign sclk_rise = !sclk_d && sclk_s;
  assign sclk_fall = sclk_d && !sclk_s;

  always_comb begin
    status            = '0;
    status[NS-1:0]    = sw_s;
    status[FW-1]      = irq;
  end

  swmon_shift #(.FRAME_W(FW)) u_shift (
    .clk_i, .rst_ni, .frame_i(frame), .cs_fall_i(cs_fall),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .si_i(si_s),
    .status_i(status), .so_o, .rx_o(rx), .full_o(full));

  swmon_irq #(.N_SW(NS)) u_irq (
    .clk_i, .rst_ni, .sw_i(sw_s), .mask_i(cmd_q[NS-1:0]),
    .frame_i(frame), .cs_rise_i(cs_rise), .irq_o(irq));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cmd_q <= '0;
    else if (cs_rise && full) cmd_q <= rx;
  end

  assign cmd_o   = cmd_q;
  assign irq_no  = !irq;
  assign so_oe_o = frame;

  AST_SHORT_FRAME_KEEPS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise && !full |=> $stable(cmd_q)); // R6
  AST_CMD_ONLY_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_rise |=> $stable(cmd_q)); // R5
endmodule

// File: tb/spi_switch_monitor_test.sv
module spi_switch_monitor_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, sclk_i = 1'b0, si_i = 1'b0;
  logic        so_o, so_oe_o, irq_no;
  logic [21:0] sw_i = '0;
  logic [23:0] cmd_o;

  int checks = 0, failures = 0;
  logic [23:0] exp_q[$], got_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  spi_switch_monitor uut (
    .clk_i(clk), .rst_ni, .cs_ni, .sclk_i, .si_i, .so_o, .so_oe_o,
    .sw_i, .irq_no, .cmd_o);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] stat(input logic irq, input logic [21:0] s);
    return {irq, 1'b0, s};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected word, shifts a frame, pushes observed word
  task automatic frame(input logic [23:0] cmd, input int nbits, input bit chk,
                       input logic [23:0] exp, input string tag,
                       input int chg_at, input logic [21:0] chg_sw);
    logic [23:0] rx = '0;
    if (chk) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    cs_ni = 1'b0;
    wait_clk(8);
    if (chk) check("R10 oe in frame", {31'd0, so_oe_o}, 32'd1);
    for (int i = 0; i < nbits; i++) begin
      sclk_i = 1'b1;
      si_i   = (i < 24) ? cmd[23-i] : 1'b0;
      wait_clk(8);
      rx = {rx[22:0], so_o};
      if (i == chg_at) sw_i = chg_sw;
      sclk_i = 1'b0;
      wait_clk(8);
    end
    cs_ni = 1'b1;
    wait_clk(8);
    if (chk) got_q.push_back(rx);
  endtask

  // monitor: compares observed frames against expectations
  initial begin
    forever begin
      wait (got_q.size() > 0);
      check(tag_q.pop_front(), {8'd0, got_q.pop_front()}, {8'd0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [21:0] a, b, c;
    a = 22'h2A5A5;
    b = 22'h15A3C;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(4);
    check("R10 reset irq_no", {31'd0, irq_no}, 32'd1);
    check("R10 reset so_oe", {31'd0, so_oe_o}, 32'd0);
    check("R10 reset cmd", {8'd0, cmd_o}, 32'd0);

    // enable all inputs, read idle status
    frame(24'h3FFFFF, 24, 1, stat(0, 22'd0), "R2 R3 idle status", -1, '0);
    check("R1 cmd commit", {8'd0, cmd_o}, 32'h3FFFFF);
    check("R10 oe idle", {31'd0, so_oe_o}, 32'd0);

    sw_i = a;
    wait_clk(10);
    check("R7 enabled change", {31'd0, irq_no}, 32'd0);
    frame(24'h3FFFFF, 24, 1, stat(1, a), "R3 irq flag and switches", -1, '0);
    check("R9 rise releases irq", {31'd0, irq_no}, 32'd1);

    // change lands mid-frame
    frame(24'h3FFFFF, 24, 1, stat(0, a), "R4 snapshot at cs fall", 10, b);
    check("R9 irq held after mid-frame change", {31'd0, irq_no}, 32'd0);
    frame(24'h3FFFFF, 24, 1, stat(1, b), "R3 held flag next frame", -1, '0);
    check("R9 release after clean frame", {31'd0, irq_no}, 32'd1);

    // mask to input 0 only
    frame(24'h000001, 24, 1, stat(0, b), "R2 status under new cmd", -1, '0);
    check("R1 cmd commit 2", {8'd0, cmd_o}, 32'h000001);
    c = b ^ 22'h000020;
    sw_i = c;
    wait_clk(10);
    check("R8 masked change ignored", {31'd0, irq_no}, 32'd1);
    frame(24'h000001, 24, 1, stat(0, c), "R8 no flag latched", -1, '0);
    c = c ^ 22'h000001;
    sw_i = c;
    wait_clk(10);
    check("R7 enabled bit0 change", {31'd0, irq_no}, 32'd0);
    frame(24'h000001, 24, 1, stat(1, c), "R3 flag bit0", -1, '0);
    check("R9 release 2", {31'd0, irq_no}, 32'd1);

    // wrong-length frames
    frame(24'hABCDEF, 16, 0, '0, "", -1, '0);
    check("R6 short frame discarded", {8'd0, cmd_o}, 32'h000001);
    frame(24'h123456, 25, 0, '0, "", -1, '0);
    check("R6 long frame discarded", {8'd0, cmd_o}, 32'h000001);

    // activity with CS high
    for (int i = 0; i < 30; i++) begin
      sclk_i = ~sclk_i;
      si_i   = i[1];
      wait_clk(5);
      if (i == 15) check("R5 oe low while cs high", {31'd0, so_oe_o}, 32'd0);
    end
    sclk_i = 1'b0;
    wait_clk(8);
    check("R5 cmd unchanged by idle clocks", {8'd0, cmd_o}, 32'h000001);
    check("R5 irq unaffected", {31'd0, irq_no}, 32'd1);

    frame(24'hC3F0A5, 24, 1, stat(0, c), "R2 final status", -1, '0);
    check("R1 cmd commit 3", {8'd0, cmd_o}, 32'hC3F0A5);

    wait_clk(10);
    check("R2 scoreboard drained", got_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule